// File: doc/BRIEF.md
# PLL Lock Qualifier with Programmable Hold-Off

This block turns the raw lock flag of a PLL into a lock indication that system
control logic can rely on. A PLL that is still acquiring the reference clock can
report lock and then lose it again several times before it settles. Logic that
consumes that flag directly can see false starts. The block runs in the
reference clock domain. It first resynchronizes the raw flag through a two-flop
synchronizer. It then holds its gated output low until a programmable number of
reference clock rising edges has passed since the PLL was enabled.

When the hold-off window has expired, the counter stops counting. From then on
the gated output follows the synchronized raw flag, so a later loss of lock
still reaches the consumer. The window starts again only when the enable input
drops and is then raised again, or when the block is reset. The synchronized,
ungated flag is also brought out, so that monitoring logic can watch the
acquisition as it happens.

Top module: `lock_gate`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` drives `lock_raw_o` and `lock_gated_o` low at once. Both stay low while the reset is held, whatever `raw_lock_i` does.
- R2: While `pll_en_i` is low, the hold-off counter is held at zero, and `lock_gated_o` is low after the next rising edge.
- R3: `hold_cnt_i` is an unsigned 20-bit count N. The PLL is enabled before rising edge 1 and the synchronized lock is high. Then `lock_gated_o` stays low through edge N and goes high after edge N+1.
- R4: Toggling of `raw_lock_i` during the hold-off window never appears on `lock_gated_o`.
- R5: `lock_gated_o` is high only when the synchronized lock was high at the previous edge. A drop of `raw_lock_i` shows as a low `lock_gated_o` after the third rising edge.
- R6: Once the count reaches N, the counter saturates and stops counting. A raw lock that returns reappears on `lock_gated_o` three edges later, with no new hold-off.
- R7: `lock_raw_o` equals `raw_lock_i` delayed by exactly two rising edges.
- R8: Dropping `pll_en_i` and raising it again restarts the hold-off from zero.
- R9: With N = 0, `lock_gated_o` follows the synchronized lock from the first rising edge after enable.
- R10: Releasing reset while `pll_en_i` is high restarts the hold-off from zero. The synchronizer also restarts, from low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all state moves on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up reset) |
| pll_en_i | input | 1 | PLL enable, synchronous to `clk_i`; high enables, low clears |
| raw_lock_i | input | 1 | Raw lock flag from the PLL, asynchronous |
| hold_cnt_i | input | 20 | Hold-off length in reference clock rising edges |
| lock_raw_o | output | 1 | Synchronized, ungated lock flag |
| lock_gated_o | output | 1 | Lock qualified by the expired hold-off window |

## Verification
The bound checker checks the following on every cycle:
- the gated lock is never high while the enable is low or the synchronized flag is low;
- the gated lock never rises before an independent count of enabled edges reaches the programmed value;
- the ungated output is exactly the raw input two edges late;
- the saturated counter never moves.

Only the directed scenarios can show some other behaviours:
- the exact edge on which the gated lock first rises;
- that a lock returning after saturation needs no new hold-off;
- the restart after re-enable and after reset;
- the zero-count case.

// File: rtl/lock_gate_pkg.sv
package lock_gate_pkg;
  localparam int unsigned HOLD_W_DEF      = 20;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hold_counter.sv
module hold_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // >= keeps the counter parked if the limit is lowered mid-run
  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lock_qual.sv
module lock_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic lock_i,
  output logic gated_o
);
  logic gated_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) gated_q <= 1'b0;
    else         gated_q <= en_i & done_i & lock_i;

  assign gated_o = gated_q;
endmodule

// File: rtl/lock_gate.sv
module lock_gate
  import lock_gate_pkg::*;
#(
  parameter int unsigned HOLD_W      = HOLD_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pll_en_i,
  input  logic              raw_lock_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  output logic              lock_raw_o,
  output logic              lock_gated_o
);
  logic              lock_sync;
  logic              hold_done;
  logic [HOLD_W-1:0] cnt_q;

  lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lock_i),
    .q_o   (lock_sync)
  );

  hold_counter #(.W(HOLD_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pll_en_i),
    .limit_i(hold_cnt_i),
    .cnt_o  (cnt_q),
    .done_o (hold_done)
  );

  lock_qual u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pll_en_i),
    .done_i (hold_done),
    .lock_i (lock_sync),
    .gated_o(lock_gated_o)
  );

  assign lock_raw_o = lock_sync;
endmodule

// File: rtl/lock_gate_chk.sv
module lock_gate_chk #(
  parameter int unsigned HOLD_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pll_en_i,
  input logic              raw_lock_i,
  input logic [HOLD_W-1:0] hold_cnt_i,
  input logic              lock_raw_o,
  input logic              lock_gated_o,
  input logic [HOLD_W-1:0] cnt_i
);
  logic [HOLD_W:0] en_edges;
  logic [1:0]      age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               en_edges <= '0;
    else if (!pll_en_i)        en_edges <= '0;
    else if (en_edges != '1)   en_edges <= en_edges + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  p_off_when_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_i |=> !lock_gated_o);

  // R3
  p_no_early_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_i && (en_edges < {1'b0, hold_cnt_i})) |=> !lock_gated_o);

  // R5
  p_needs_sync_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_raw_o |=> !lock_gated_o);

  // R6
  p_cnt_saturates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_i && (cnt_i >= hold_cnt_i)) |=> $stable(cnt_i));

  // R7
  p_raw_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (lock_raw_o == $past(raw_lock_i, 2)));
endmodule

bind lock_gate lock_gate_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pll_en_i    (pll_en_i),
  .raw_lock_i  (raw_lock_i),
  .hold_cnt_i  (hold_cnt_i),
  .lock_raw_o  (lock_raw_o),
  .lock_gated_o(lock_gated_o),
  .cnt_i       (cnt_q)
);

// File: tb/sim_lock_gate.sv
`timescale 1ns/1ps
module sim_lock_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pll_en_i = 1'b0;
  logic        raw_lock_i = 1'b0;
  logic [19:0] hold_cnt_i = '0;
  logic        lock_raw_o;
  logic        lock_gated_o;
  int          checks = 0;
  int          errors = 0;

  always #4 clk_i = ~clk_i;

  lock_gate u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pll_en_i    (pll_en_i),
    .raw_lock_i  (raw_lock_i),
    .hold_cnt_i  (hold_cnt_i),
    .lock_raw_o  (lock_raw_o),
    .lock_gated_o(lock_gated_o)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    raw_lock_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R1", "raw in reset", lock_raw_o, 1'b0);
      check("R1", "gated in reset", lock_gated_o, 1'b0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_disabled();
    pll_en_i = 1'b0;
    hold_cnt_i = 20'd0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R2", "gated while disabled", lock_gated_o, 1'b0);
    end
    check("R7", "raw after sync", lock_raw_o, 1'b1);
  endtask

  task automatic t_hold_five();
    hold_cnt_i = 20'd5;
    pll_en_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check("R3", $sformatf("gated after edge %0d", k), lock_gated_o, k >= 6);
    end
  endtask

  task automatic t_toggle_acq();
    pll_en_i = 1'b0;
    tick();
    hold_cnt_i = 20'd10;
    pll_en_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      raw_lock_i = k[0];
      tick();
      check("R4", $sformatf("gated during toggling edge %0d", k), lock_gated_o, 1'b0);
    end
    raw_lock_i = 1'b1;
    for (int k = 9; k <= 11; k++) begin
      tick();
      check("R4", $sformatf("gated after toggling edge %0d", k), lock_gated_o, k >= 11);
    end
  endtask

  task automatic t_drop_and_return();
    raw_lock_i = 1'b0;
    tick();
    check("R7", "raw one edge after drop", lock_raw_o, 1'b1);
    tick();
    check("R7", "raw two edges after drop", lock_raw_o, 1'b0);
    check("R5", "gated two edges after drop", lock_gated_o, 1'b1);
    tick();
    check("R5", "gated three edges after drop", lock_gated_o, 1'b0);
    tick();
    raw_lock_i = 1'b1;
    tick();
    tick();
    check("R6", "gated two edges after return", lock_gated_o, 1'b0);
    tick();
    check("R6", "gated three edges after return", lock_gated_o, 1'b1);
  endtask

  task automatic t_reenable();
    pll_en_i = 1'b0;
    tick();
    check("R2", "gated after disable", lock_gated_o, 1'b0);
    hold_cnt_i = 20'd3;
    pll_en_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R8", $sformatf("gated re-enable edge %0d", k), lock_gated_o, k >= 4);
    end
  endtask

  task automatic t_zero_hold();
    pll_en_i = 1'b0;
    tick();
    tick();
    hold_cnt_i = 20'd0;
    pll_en_i = 1'b1;
    tick();
    check("R9", "gated first edge with zero hold", lock_gated_o, 1'b1);
  endtask

  task automatic t_reset_midrun();
    hold_cnt_i = 20'd4;
    #1 rst_ni = 1'b0;
    #1;
    check("R1", "gated async reset", lock_gated_o, 1'b0);
    check("R1", "raw async reset", lock_raw_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R10", $sformatf("gated after reset edge %0d", k), lock_gated_o, k >= 5);
    end
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_disabled();
    t_hold_five();
    t_toggle_acq();
    t_drop_and_return();
    t_reenable();
    t_zero_hold();
    t_reset_midrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule